// File: doc/BRIEF.md
# Content-Adaptive Backlight Controller

This block watches a stream of pixels one frame at a time. It records the brightest valid pixel and the mean pixel level of each frame. When the next frame starts, it picks a new backlight duty from that brightest value. It also derives a pixel gain that makes up for the dimmer backlight. Pixels are multiplied by the gain, so a dark scene can run on a weaker backlight and still look the same to the viewer. This saves backlight power.

The duty does not jump straight to its new target. It moves toward it by a bounded amount at each frame boundary. The gain always follows the duty that is in force, so the backlight and the pixel compensation change together and without flicker. Software sets a floor for the duty and the size of the per-frame step. A bypass input forces full backlight and unity gain.

Pixels are 8 bits wide. The gain has 6 fraction bits. The frame size is a power of two, 2^FRAME_LOG2 valid pixels per frame, and the mean level is computed by a shift.

Top module: `cabl_ctrl`

## Requirements
- R1: After reset, `pwm_duty` is 255 and `frame_apl` is 0. Pixels of the first frame leave the block with unity gain, so the output equals the input.
- R2: Only beats with `pix_valid` high count toward frame statistics. The data, start-of-frame and end-of-line inputs of an invalid beat have no effect. `pix_sof` high on a valid beat marks the first pixel of a frame.
- R3: The duty target for a frame is the larger of the previous frame's maximum valid pixel and `cfg_min_bl`.
- R4: At each frame start the duty moves toward the target by at most `cfg_step`. It lands exactly on the target when the target is within one step. A step of 0 holds the duty.
- R5: Statistics gathered in frame N take effect in frame N+1. The new duty appears on `pwm_duty` one clock after the valid start-of-frame beat, and the new gain applies to that first pixel onward.
- R6: The gain is floor(255*64/duty), or 16383 when the duty is 0. The output pixel is min(255, (pixel*gain) >> 6), so it is never below the input pixel.
- R7: Every input beat appears at the output two clocks later, with its valid, start-of-frame and end-of-line flags unchanged.
- R8: At each frame start, `frame_apl` takes the sum of the previous frame's valid pixels shifted right by FRAME_LOG2, saturated to 255.
- R9: While `cfg_bypass` is high, `pwm_duty` reads 255 and pixels pass with unity gain. A frame start under bypass resets the tracked duty to 255, so the next slew after bypass is released starts from full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input beat carries a pixel |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_data | input | 8 | Input pixel level |
| cfg_min_bl | input | 8 | Lowest duty target allowed |
| cfg_step | input | 8 | Largest duty change per frame |
| cfg_bypass | input | 1 | Force full duty and unity gain |
| out_valid | output | 1 | Output beat carries a pixel |
| out_sof | output | 1 | Delayed start-of-frame flag |
| out_eol | output | 1 | Delayed end-of-line flag |
| out_data | output | 8 | Gain-compensated pixel |
| pwm_duty | output | 8 | Backlight duty, 255 is full |
| frame_apl | output | 8 | Mean level of the last complete frame |

## Verification
The bench sweeps frame maxima from 0 to 255 with a full-size step and compares every output pixel against a gain computed arithmetically. A wrong divisor or a missing saturation would show up as wrong pixel values. Invalid beats carrying 255 with both markers set are inserted inside each frame: a design that counted them would pin the duty at full, and one that acted on their start flag would close frames early. The duty floor, slew limiting (including a zero step) and a black frame that drives the duty to 0 are each exercised; the black frame catches a divide-by-zero path. Bypass entry and release are checked to show an immediate full duty and a slew that restarts from 255. A design that kept the dimmed value through bypass would fail that check.

// File: rtl/cabl_pkg.sv
package cabl_pkg;
    localparam int PIX_W  = 8;
    localparam int FRAC_W = 6;
    localparam int GAIN_W = PIX_W + FRAC_W;
    localparam int PROD_W = PIX_W + GAIN_W;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [GAIN_W-1:0] gain_t;

    localparam pix_t  FULL  = {PIX_W{1'b1}};
    localparam gain_t UNITY = {{(GAIN_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        pix_t data;
    } beat_t;

    // Move cur toward tgt by no more than step.
    function automatic pix_t slew(pix_t cur, pix_t tgt, pix_t step);
        pix_t d;
        if (tgt >= cur) begin
            d = tgt - cur;
            return (d > step) ? cur + step : tgt;
        end
        d = cur - tgt;
        return (d > step) ? cur - step : tgt;
    endfunction

    // Compensation gain for a duty, fixed point with FRAC_W fraction bits.
    function automatic gain_t gain_of(pix_t duty);
        gain_t num;
        num = {FULL, {FRAC_W{1'b0}}};
        if (duty == '0) return '1;
        return num / {{FRAC_W{1'b0}}, duty};
    endfunction

    // Multiply a pixel by a gain and saturate to full scale.
    function automatic pix_t scale(pix_t p, gain_t g);
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] sh;
        prod = {{GAIN_W{1'b0}}, p} * {{PIX_W{1'b0}}, g};
        sh   = prod >> FRAC_W;
        if (sh > {{GAIN_W{1'b0}}, FULL}) return FULL;
        return sh[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/cabl_stats.sv
module cabl_stats import cabl_pkg::*; #(
    parameter int FRAME_LOG2 = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_sof,
    input  pix_t in_data,
    output logic frame_close,
    output pix_t frame_max,
    output pix_t frame_apl
);
    localparam int SUM_W = PIX_W + FRAME_LOG2 + 1;
    typedef logic [SUM_W-1:0] sum_t;

    pix_t acc_max_q;
    sum_t acc_sum_q;
    logic seen_q;
    pix_t apl_q;
    sum_t mean;
    sum_t din_ext;

    assign din_ext     = {{(SUM_W-PIX_W){1'b0}}, in_data};
    assign mean        = acc_sum_q >> FRAME_LOG2;
    assign frame_close = in_valid && in_sof && seen_q;
    assign frame_max   = acc_max_q;
    assign frame_apl   = apl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_max_q <= '0;
            acc_sum_q <= '0;
            seen_q    <= 1'b0;
            apl_q     <= '0;
        end else if (in_valid) begin
            if (in_sof) begin
                if (seen_q)
                    apl_q <= (mean > {{(SUM_W-PIX_W){1'b0}}, FULL}) ? FULL : mean[PIX_W-1:0];
                acc_max_q <= in_data;
                acc_sum_q <= din_ext;
                seen_q    <= 1'b1;
            end else begin
                if (in_data > acc_max_q) acc_max_q <= in_data;
                acc_sum_q <= acc_sum_q + din_ext;
            end
        end
    end
endmodule

// File: rtl/cabl_level.sv
module cabl_level import cabl_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_close,
    input  pix_t  frame_max,
    input  pix_t  min_bl,
    input  pix_t  step,
    input  logic  bypass,
    output pix_t  duty_q,
    output gain_t gain_q
);
    pix_t target;
    pix_t next_duty;

    always_comb begin
        target    = (frame_max > min_bl) ? frame_max : min_bl;
        next_duty = bypass ? FULL : slew(duty_q, target, step);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= FULL;
            gain_q <= UNITY;
        end else if (frame_close) begin
            duty_q <= next_duty;
            gain_q <= gain_of(next_duty);
        end
    end
endmodule

// File: rtl/cabl_scaler.sv
module cabl_scaler import cabl_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    input  gain_t gain,
    output beat_t out_beat
);
    beat_t s1_q;
    beat_t s2_q;

    assign out_beat = s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= in_beat;
            s2_q <= '{valid: s1_q.valid, sof: s1_q.sof, eol: s1_q.eol,
                      data: scale(s1_q.data, gain)};
        end
    end
endmodule

// File: rtl/cabl_ctrl.sv
module cabl_ctrl import cabl_pkg::*; #(
    parameter int FRAME_LOG2 = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_eol,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PIX_W-1:0] cfg_min_bl,
    input  logic [PIX_W-1:0] cfg_step,
    input  logic             cfg_bypass,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_data,
    output logic [PIX_W-1:0] pwm_duty,
    output logic [PIX_W-1:0] frame_apl
);
    beat_t in_beat;
    beat_t res_beat;
    logic  frame_close;
    pix_t  frame_max;
    pix_t  duty_q;
    gain_t gain_q;
    gain_t gain_used;

    always_comb begin
        in_beat = '{valid: pix_valid, sof: pix_sof, eol: pix_eol, data: pix_data};
    end

    cabl_stats #(.FRAME_LOG2(FRAME_LOG2)) i_stats (
        .clk(clk), .rst(rst),
        .in_valid(pix_valid), .in_sof(pix_sof), .in_data(pix_data),
        .frame_close(frame_close), .frame_max(frame_max), .frame_apl(frame_apl)
    );

    cabl_level i_level (
        .clk(clk), .rst(rst),
        .frame_close(frame_close), .frame_max(frame_max),
        .min_bl(cfg_min_bl), .step(cfg_step), .bypass(cfg_bypass),
        .duty_q(duty_q), .gain_q(gain_q)
    );

    assign gain_used = cfg_bypass ? UNITY : gain_q;
    assign pwm_duty  = cfg_bypass ? FULL : duty_q;

    cabl_scaler i_scaler (
        .clk(clk), .rst(rst),
        .in_beat(in_beat), .gain(gain_used), .out_beat(res_beat)
    );

    assign out_valid = res_beat.valid;
    assign out_sof   = res_beat.sof;
    assign out_eol   = res_beat.eol;
    assign out_data  = res_beat.data;
endmodule

// File: rtl/cabl_ctrl_chk.sv
module cabl_ctrl_chk import cabl_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic             pix_sof,
    input logic [PIX_W-1:0] pix_data,
    input logic [PIX_W-1:0] cfg_step,
    input logic             cfg_bypass,
    input logic [PIX_W-1:0] pwm_duty,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_data
);
    logic [1:0] age;
    pix_t       prev_duty;
    pix_t       prev_step;
    logic       prev_byp;
    logic       prev_sofv;
    pix_t       duty_delta;

    always_ff @(posedge clk) begin
        if (rst) begin
            age       <= '0;
            prev_duty <= FULL;
            prev_step <= '0;
            prev_byp  <= 1'b0;
            prev_sofv <= 1'b0;
        end else begin
            if (age != 2'd3) age <= age + 2'd1;
            prev_duty <= pwm_duty;
            prev_step <= cfg_step;
            prev_byp  <= cfg_bypass;
            prev_sofv <= pix_valid && pix_sof;
        end
    end

    assign duty_delta = (pwm_duty >= prev_duty) ? pwm_duty - prev_duty : prev_duty - pwm_duty;

    AST_TWO_CYCLE_FLOW: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R7

    AST_NEVER_DIMS: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && out_valid) |-> (out_data >= $past(pix_data, 2))); // R6

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && out_valid && $past(cfg_bypass)) |-> (out_data == $past(pix_data, 2))); // R9

    AST_DUTY_SLEW: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !cfg_bypass && !prev_byp) |-> (duty_delta <= prev_step)); // R4

    AST_DUTY_AT_SOF: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !cfg_bypass && !prev_byp && pwm_duty != prev_duty) |-> prev_sofv); // R5
endmodule

bind cabl_ctrl cabl_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_data(pix_data), .cfg_step(cfg_step), .cfg_bypass(cfg_bypass),
    .pwm_duty(pwm_duty), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_cabl_ctrl.sv
module test_cabl_ctrl;
    import cabl_pkg::*;
    localparam int LOG2 = 4;
    localparam int NPIX = 1 << LOG2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic pix_valid, pix_sof, pix_eol, cfg_bypass;
    logic [7:0] pix_data, cfg_min_bl, cfg_step;
    logic out_valid, out_sof, out_eol;
    logic [7:0] out_data, pwm_duty, frame_apl;

    cabl_ctrl #(.FRAME_LOG2(LOG2)) i_cabl_ctrl (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_data(pix_data), .cfg_min_bl(cfg_min_bl),
        .cfg_step(cfg_step), .cfg_bypass(cfg_bypass), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_data(out_data),
        .pwm_duty(pwm_duty), .frame_apl(frame_apl)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int m_bl = 255;
    int m_apl = 0;
    int acc_max = 0;
    int acc_sum = 0;
    bit seen = 0;
    bit chk_duty = 0;
    string cur_req = "R1";
    logic [9:0] exp_q[$];

    function automatic int m_gain(int bl);
        if (bl == 0) return 16383;
        return (255 * 64) / bl;
    endfunction

    function automatic int m_scale(int p, int g);
        int v;
        v = (p * g) >> 6;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int m_slew(int c, int t, int s);
        if (t >= c) return (t - c > s) ? c + s : t;
        return (c - t > s) ? c - s : t;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_and_check();
        @(negedge clk);
        if (chk_duty) begin
            check({cur_req, " duty at frame start"}, pwm_duty, cfg_bypass ? 255 : m_bl);
            check("R8 mean level", frame_apl, m_apl);
            chk_duty = 0;
        end
    endtask

    task automatic put(int p, bit sof, bit eol);
        int g;
        edge_and_check();
        pix_valid = 1'b1;
        pix_sof   = sof;
        pix_eol   = eol;
        pix_data  = 8'(p);
        if (sof) begin
            if (seen) begin
                m_apl = ((acc_sum >> LOG2) > 255) ? 255 : (acc_sum >> LOG2);
                m_bl  = cfg_bypass ? 255
                      : m_slew(m_bl, (acc_max > cfg_min_bl) ? acc_max : int'(cfg_min_bl), cfg_step);
                chk_duty = 1;
            end
            acc_max = p;
            acc_sum = p;
            seen = 1;
        end else begin
            if (p > acc_max) acc_max = p;
            acc_sum += p;
        end
        g = cfg_bypass ? 64 : m_gain(m_bl);
        exp_q.push_back({sof, eol, 8'(m_scale(p, g))});
    endtask

    // Invalid beat with misleading contents: must be ignored (R2).
    task automatic idle();
        edge_and_check();
        pix_valid = 1'b0;
        pix_sof   = 1'b1;
        pix_eol   = 1'b1;
        pix_data  = 8'd255;
    endtask

    task automatic frame(int mx, int seed);
        for (int i = 0; i < NPIX; i++) begin
            int p;
            if (i % 5 == 2) idle();
            p = (i == 7) ? mx : ((i * 37 + seed) % (mx + 1));
            put(p, i == 0, (i % 4) == 3);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R7 unexpected output beat actual=1 expected=0");
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check("R5/R6 pixel", out_data, e[7:0]);
                check("R7 markers", {out_sof, out_eol}, e[9:8]);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_data = 0;
        cfg_min_bl = 0; cfg_step = 8'd255; cfg_bypass = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset duty", pwm_duty, 255);
        check("R1 reset mean", frame_apl, 0);

        // R1: first frame at unity gain, then sweep of maxima (R2, R6)
        cur_req = "R2";
        for (int m = 0; m <= 255; m += 15) frame(m, m);
        frame(200, 3);

        // R3: floor on target
        cur_req = "R3";
        cfg_min_bl = 8'd100;
        frame(40, 1);
        frame(10, 2);
        frame(180, 5);
        frame(0, 0);

        // R4: slew limit, then hold with step 0
        cur_req = "R4";
        cfg_min_bl = 8'd0;
        cfg_step = 8'd10;
        frame(30, 4);
        frame(30, 6);
        frame(255, 7);
        frame(255, 8);
        cfg_step = 8'd0;
        frame(60, 9);
        frame(60, 10);
        cfg_step = 8'd255;
        frame(0, 0);

        // R6: black frame drives duty to zero, gain saturates
        cur_req = "R6";
        frame(0, 0);
        frame(90, 11);
        frame(5, 12);

        // R9: bypass entry and release
        cur_req = "R9";
        cfg_step = 8'd20;
        repeat (3) idle();
        @(negedge clk);
        cfg_bypass = 1'b1;
        #1;
        check("R9 bypass duty", pwm_duty, 255);
        frame(50, 13);
        frame(20, 14);
        repeat (3) idle();
        @(negedge clk);
        cfg_bypass = 1'b0;
        frame(20, 15);
        frame(20, 16);

        repeat (4) idle();
        repeat (3) @(negedge clk);
        check("R7 all beats delivered", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule